// File: doc/BRIEF.md
# Low-Power Mode Controller

This block decides when a processor's clocks and oscillator run. The core issues a one-cycle sleep request. A configuration bit chooses one of two depths. In light sleep only the CPU clock is gated and peripherals keep working. In deep standby the CPU clock, the peripheral clock and the oscillator enable are all dropped. Each depth has its own set of wake sources. Waking from deep standby first restarts the oscillator. Clocks come back and the exception strobe fires only after a programmable settling countdown.

Two active-low pins override everything. The hardware-standby pin forces every clock and the oscillator off. The reset pin holds a reset state and starts reset exception processing when it is released. The whole block runs on one free-running reference clock that stays alive in every state.

Top module: `lpm_ctrl`

## Requirements
- R1: A sleep request in run mode with `standbySel`=0 enters light sleep on the next cycle: `cpuClkEn`=0, `periClkEn`=1, `oscEn`=1.
- R2: A sleep request in run mode with `standbySel`=1 enters deep standby on the next cycle: `cpuClkEn`, `periClkEn` and `oscEn` are all 0.
- R3: Light sleep returns to run mode (all enables 1) one cycle after a wake source is seen, and `wakeExcStrobe` is high for exactly that first run cycle. The wake sources are the non-maskable request, an enabled external line, the enabled auxiliary source and the peripheral request. Reset low and hardware-standby low also end light sleep.
- R4: In light sleep, an external line whose enable bit is 0 does not wake the block. While `cpuMask`=1, no maskable source wakes it: external lines, the auxiliary source and the peripheral request are all ignored.
- R5: Deep standby wakes only on the non-maskable request, an enabled external line, the enabled auxiliary source, reset or hardware standby. The peripheral request and a disabled auxiliary source are ignored.
- R6: An interrupt wake from deep standby sets `oscEn`=1 on the next cycle while both clocks stay 0. This holds for exactly 2^(7+n) cycles, where n is the value of `settleSel` sampled at the wake. Run mode follows, with `wakeExcStrobe` high for its first cycle.
- R7: With `cpuMask`=1, enabled external lines and the enabled auxiliary source do not clear deep standby.
- R8: One cycle after `hwStbyN` is seen low, every output is 0, whatever the mode.
- R9: While `resetPinN` is low and `hwStbyN` is high, `cpuClkEn`=0, `periClkEn`=0, `oscEn`=1 and both strobes are 0. The first cycle after the pin is seen high, the block is in run mode with `resetExcStrobe` high for one cycle.
- R10: Priority is hardware standby, then reset, then interrupt wake. With both pins low, `oscEn` is 0. A wake request together with reset low yields the reset state and no `wakeExcStrobe`.
- R11: A sleep request outside run mode is ignored. In light sleep, a request with `standbySel`=1 leaves the peripheral clock and the oscillator running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| sleepReq | input | 1 | One-cycle sleep request from the core |
| standbySel | input | 1 | 0 selects light sleep, 1 selects deep standby |
| settleSel | input | 3 | Oscillator settling code n, wait 2^(7+n) cycles |
| nmiReq | input | 1 | Non-maskable interrupt request |
| irqReq | input | 8 | External maskable interrupt lines |
| irqEn | input | 8 | Enable bit per external line |
| auxWakeReq | input | 1 | Extra maskable wake source |
| auxWakeEn | input | 1 | Enable for the extra wake source |
| periphIrqReq | input | 1 | Enabled on-chip peripheral interrupt (light sleep only) |
| cpuMask | input | 1 | CPU masks all interrupts except the non-maskable one |
| resetPinN | input | 1 | Active-low reset pin |
| hwStbyN | input | 1 | Active-low hardware-standby pin |
| cpuClkEn | output | 1 | CPU clock enable |
| periClkEn | output | 1 | Peripheral clock enable |
| oscEn | output | 1 | Oscillator enable |
| wakeExcStrobe | output | 1 | One-cycle pulse starting interrupt exception handling |
| resetExcStrobe | output | 1 | One-cycle pulse starting reset exception handling |

## Verification
All inputs are sampled on a rising edge. Every output is a decode of state registered on that edge, so a mode change caused by a stimulus shows one cycle later. A wake strobe appears in the first run cycle, and a deep-standby wake returns to run 2^(7+n) cycles after the wake edge. The bench changes inputs on falling edges only. A behavioural model advances on each rising edge, and all five outputs are compared with it on every falling edge, so each result is checked in the exact cycle it is due, including every cycle of the settling countdown.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic [2:0] {
    ST_RESET  = 3'd0,
    ST_RUN    = 3'd1,
    ST_SLEEP  = 3'd2,
    ST_SSTBY  = 3'd3,
    ST_SETTLE = 3'd4,
    ST_HWSTBY = 3'd5
  } lpmState_e;

  // control -> datapath
  typedef struct packed {
    logic loadSettle;
    logic runSettle;
  } dpCmd_t;

  // datapath -> control
  typedef struct packed {
    logic wakeSleep;
    logic wakeStby;
    logic settleDone;
  } dpStat_t;

endpackage

// File: rtl/lpm_datapath.sv
module lpm_datapath
  import lpm_pkg::*;
#(
  parameter int NUM_IRQ   = 8,
  parameter int SEL_W     = 3,
  parameter int BASE_LOG2 = 7
) (
  input  logic               clk,
  input  dpCmd_t             cmd,
  input  logic [SEL_W-1:0]   settleSel,
  input  logic               nmiReq,
  input  logic [NUM_IRQ-1:0] irqReq,
  input  logic [NUM_IRQ-1:0] irqEn,
  input  logic               auxWakeReq,
  input  logic               auxWakeEn,
  input  logic               periphIrqReq,
  input  logic               cpuMask,
  output dpStat_t            stat
);

  localparam int CNT_W = BASE_LOG2 + (1 << SEL_W);

  logic [NUM_IRQ-1:0] irqHit;
  logic               anyIrq;
  logic               auxHit;
  logic [CNT_W-1:0]   settleCnt;
  logic [CNT_W-1:0]   settleLoad;

  // per-line enable gating
  for (genvar gi = 0; gi < NUM_IRQ; gi++) begin : g_irqGate
    assign irqHit[gi] = irqReq[gi] & irqEn[gi];
  end

  assign anyIrq = |irqHit;
  assign auxHit = auxWakeReq & auxWakeEn;

  // light sleep also accepts peripheral interrupts; deep standby does not
  assign stat.wakeSleep  = nmiReq | (~cpuMask & (anyIrq | auxHit | periphIrqReq));
  assign stat.wakeStby   = nmiReq | (~cpuMask & (anyIrq | auxHit));
  assign stat.settleDone = (settleCnt == '0);

  // wait of 2^(BASE_LOG2+n) cycles, counted as load value N-1 down to zero
  assign settleLoad = (CNT_W'(1) << (BASE_LOG2 + int'(settleSel))) - CNT_W'(1);

  always_ff @(posedge clk) begin
    if (cmd.loadSettle) begin
      settleCnt <= settleLoad;
    end else if (cmd.runSettle && (settleCnt != '0)) begin
      settleCnt <= settleCnt - CNT_W'(1);
    end
  end

endmodule

// File: rtl/lpm_control.sv
module lpm_control
  import lpm_pkg::*;
(
  input  logic      clk,
  input  logic      sleepReq,
  input  logic      standbySel,
  input  logic      resetPinN,
  input  logic      hwStbyN,
  input  dpStat_t   stat,
  output dpCmd_t    cmd,
  output lpmState_e state,
  output logic      cpuClkEn,
  output logic      periClkEn,
  output logic      oscEn,
  output logic      wakeExcStrobe,
  output logic      resetExcStrobe
);

  lpmState_e nextState;
  logic      nextWake;
  logic      nextRst;

  always_comb begin
    nextState      = state;
    nextWake       = 1'b0;
    nextRst        = 1'b0;
    cmd.loadSettle = 1'b0;
    cmd.runSettle  = 1'b0;
    unique case (state)
      ST_HWSTBY: nextState = ST_RESET;
      ST_RESET: begin
        nextState = ST_RUN;
        nextRst   = 1'b1;
      end
      ST_RUN: begin
        if (sleepReq) nextState = standbySel ? ST_SSTBY : ST_SLEEP;
      end
      ST_SLEEP: begin
        if (stat.wakeSleep) begin
          nextState = ST_RUN;
          nextWake  = 1'b1;
        end
      end
      ST_SSTBY: begin
        if (stat.wakeStby) begin
          nextState      = ST_SETTLE;
          cmd.loadSettle = 1'b1;
        end
      end
      ST_SETTLE: begin
        cmd.runSettle = 1'b1;
        if (stat.settleDone) begin
          nextState = ST_RUN;
          nextWake  = 1'b1;
        end
      end
      default: nextState = ST_RESET;
    endcase
    // pin overrides: hardware standby first, then reset
    if (!hwStbyN) begin
      nextState      = ST_HWSTBY;
      nextWake       = 1'b0;
      nextRst        = 1'b0;
      cmd.loadSettle = 1'b0;
    end else if (!resetPinN) begin
      nextState      = ST_RESET;
      nextWake       = 1'b0;
      nextRst        = 1'b0;
      cmd.loadSettle = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    state          <= nextState;
    wakeExcStrobe  <= nextWake;
    resetExcStrobe <= nextRst;
  end

  assign cpuClkEn  = (state == ST_RUN);
  assign periClkEn = (state == ST_RUN) || (state == ST_SLEEP);
  assign oscEn     = (state == ST_RUN) || (state == ST_SLEEP) ||
                     (state == ST_SETTLE) || (state == ST_RESET);

endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
#(
  parameter int NUM_IRQ   = 8,
  parameter int SEL_W     = 3,
  parameter int BASE_LOG2 = 7
) (
  input  logic               clk,
  input  logic               sleepReq,
  input  logic               standbySel,
  input  logic [SEL_W-1:0]   settleSel,
  input  logic               nmiReq,
  input  logic [NUM_IRQ-1:0] irqReq,
  input  logic [NUM_IRQ-1:0] irqEn,
  input  logic               auxWakeReq,
  input  logic               auxWakeEn,
  input  logic               periphIrqReq,
  input  logic               cpuMask,
  input  logic               resetPinN,
  input  logic               hwStbyN,
  output logic               cpuClkEn,
  output logic               periClkEn,
  output logic               oscEn,
  output logic               wakeExcStrobe,
  output logic               resetExcStrobe
);

  dpCmd_t    dpCmd;
  dpStat_t   dpStat;
  lpmState_e curState;

  lpm_datapath #(
    .NUM_IRQ  (NUM_IRQ),
    .SEL_W    (SEL_W),
    .BASE_LOG2(BASE_LOG2)
  ) u_dp (
    .clk         (clk),
    .cmd         (dpCmd),
    .settleSel   (settleSel),
    .nmiReq      (nmiReq),
    .irqReq      (irqReq),
    .irqEn       (irqEn),
    .auxWakeReq  (auxWakeReq),
    .auxWakeEn   (auxWakeEn),
    .periphIrqReq(periphIrqReq),
    .cpuMask     (cpuMask),
    .stat        (dpStat)
  );

  lpm_control u_ctl (
    .clk           (clk),
    .sleepReq      (sleepReq),
    .standbySel    (standbySel),
    .resetPinN     (resetPinN),
    .hwStbyN       (hwStbyN),
    .stat          (dpStat),
    .cmd           (dpCmd),
    .state         (curState),
    .cpuClkEn      (cpuClkEn),
    .periClkEn     (periClkEn),
    .oscEn         (oscEn),
    .wakeExcStrobe (wakeExcStrobe),
    .resetExcStrobe(resetExcStrobe)
  );

endmodule

// File: rtl/lpm_ctrl_chk.sv
module lpm_ctrl_chk
  import lpm_pkg::*;
#(
  parameter int NUM_IRQ = 8
) (
  input logic               clk,
  input logic               sleepReq,
  input logic               standbySel,
  input logic               nmiReq,
  input logic [NUM_IRQ-1:0] irqReq,
  input logic [NUM_IRQ-1:0] irqEn,
  input logic               auxWakeReq,
  input logic               auxWakeEn,
  input logic               cpuMask,
  input logic               resetPinN,
  input logic               hwStbyN,
  input logic               cpuClkEn,
  input logic               periClkEn,
  input logic               oscEn,
  input logic               wakeExcStrobe,
  input logic               resetExcStrobe,
  input lpmState_e          state
);

  a_r1_sleep_entry: assert property (@(posedge clk) disable iff (!resetPinN || !hwStbyN)
    (state == ST_RUN && sleepReq && !standbySel) |=> (!cpuClkEn && periClkEn && oscEn));

  a_r2_standby_entry: assert property (@(posedge clk) disable iff (!resetPinN || !hwStbyN)
    (state == ST_RUN && sleepReq && standbySel) |=> (!cpuClkEn && !periClkEn && !oscEn));

  a_r3_wake_strobe_in_run: assert property (@(posedge clk) disable iff (!resetPinN || !hwStbyN)
    wakeExcStrobe |-> cpuClkEn);

  a_r4_masked_sleep_holds: assert property (@(posedge clk) disable iff (!resetPinN || !hwStbyN)
    (state == ST_SLEEP && !nmiReq && cpuMask) |=> (state == ST_SLEEP));

  a_r5_standby_wake_set: assert property (@(posedge clk) disable iff (!resetPinN || !hwStbyN)
    (state == ST_SSTBY && !nmiReq && ((irqReq & irqEn) == '0) && !(auxWakeReq && auxWakeEn))
    |=> (state == ST_SSTBY));

  a_r6_osc_before_clocks: assert property (@(posedge clk) disable iff (!resetPinN || !hwStbyN)
    (state == ST_SSTBY && nmiReq) |=> (oscEn && !cpuClkEn && !periClkEn && !wakeExcStrobe));

  a_r7_masked_standby_holds: assert property (@(posedge clk) disable iff (!resetPinN || !hwStbyN)
    (state == ST_SSTBY && !nmiReq && cpuMask) |=> !oscEn);

  a_r8_hw_standby_off: assert property (@(posedge clk)
    !hwStbyN |=> (!cpuClkEn && !periClkEn && !oscEn && !wakeExcStrobe && !resetExcStrobe));

  a_r9_reset_hold: assert property (@(posedge clk) disable iff (!hwStbyN)
    !resetPinN |=> (!cpuClkEn && !periClkEn && oscEn && !resetExcStrobe && !wakeExcStrobe));

  a_r9_reset_strobe_in_run: assert property (@(posedge clk) disable iff (!resetPinN || !hwStbyN)
    resetExcStrobe |-> cpuClkEn);

  a_r10_hw_over_reset: assert property (@(posedge clk)
    (!hwStbyN && !resetPinN) |=> !oscEn);

  a_r11_no_sleep_outside_run: assert property (@(posedge clk) disable iff (!resetPinN || !hwStbyN)
    (state == ST_SLEEP && sleepReq) |=> (state != ST_SSTBY));

endmodule

bind lpm_ctrl lpm_ctrl_chk #(.NUM_IRQ(NUM_IRQ)) u_chk (
  .clk           (clk),
  .sleepReq      (sleepReq),
  .standbySel    (standbySel),
  .nmiReq        (nmiReq),
  .irqReq        (irqReq),
  .irqEn         (irqEn),
  .auxWakeReq    (auxWakeReq),
  .auxWakeEn     (auxWakeEn),
  .cpuMask       (cpuMask),
  .resetPinN     (resetPinN),
  .hwStbyN       (hwStbyN),
  .cpuClkEn      (cpuClkEn),
  .periClkEn     (periClkEn),
  .oscEn         (oscEn),
  .wakeExcStrobe (wakeExcStrobe),
  .resetExcStrobe(resetExcStrobe),
  .state         (curState)
);

// File: tb/tb_lpm_ctrl.sv
`timescale 1ns/1ps
module tb_lpm_ctrl;

  logic       clk = 1'b0;
  logic       sleepReq = 1'b0, standbySel = 1'b0;
  logic [2:0] settleSel = 3'd0;
  logic       nmiReq = 1'b0;
  logic [7:0] irqReq = 8'h00, irqEn = 8'h00;
  logic       auxWakeReq = 1'b0, auxWakeEn = 1'b0, periphIrqReq = 1'b0, cpuMask = 1'b0;
  logic       resetPinN = 1'b0, hwStbyN = 1'b0;
  logic       cpuClkEn, periClkEn, oscEn, wakeExcStrobe, resetExcStrobe;

  int    checks = 0;
  int    failures = 0;
  int    cycles = 0;
  string curReq = "R8";
  bit    done = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  lpm_ctrl dut (
    .clk(clk), .sleepReq(sleepReq), .standbySel(standbySel), .settleSel(settleSel),
    .nmiReq(nmiReq), .irqReq(irqReq), .irqEn(irqEn), .auxWakeReq(auxWakeReq),
    .auxWakeEn(auxWakeEn), .periphIrqReq(periphIrqReq), .cpuMask(cpuMask),
    .resetPinN(resetPinN), .hwStbyN(hwStbyN), .cpuClkEn(cpuClkEn), .periClkEn(periClkEn),
    .oscEn(oscEn), .wakeExcStrobe(wakeExcStrobe), .resetExcStrobe(resetExcStrobe)
  );

  // behavioural reference: mode names as strings, wait as a plain integer
  string mMode = "hwstby";
  int    mWait = 0;
  bit    mWake = 0, mRst = 0;

  always @(posedge clk) begin
    bit maskable;
    maskable = !cpuMask && (((irqReq & irqEn) != 0) || (auxWakeReq && auxWakeEn));
    mWake = 0;
    mRst  = 0;
    if (!hwStbyN) mMode = "hwstby";
    else if (!resetPinN) mMode = "reset";
    else if (mMode == "hwstby") mMode = "reset";
    else if (mMode == "reset") begin mMode = "run"; mRst = 1; end
    else if (mMode == "run") begin
      if (sleepReq) mMode = standbySel ? "standby" : "sleep";
    end else if (mMode == "sleep") begin
      if (nmiReq || maskable || (!cpuMask && periphIrqReq)) begin mMode = "run"; mWake = 1; end
    end else if (mMode == "standby") begin
      if (nmiReq || maskable) begin mMode = "settle"; mWait = 1 << (7 + int'(settleSel)); end
    end else if (mMode == "settle") begin
      mWait--;
      if (mWait == 0) begin mMode = "run"; mWake = 1; end
    end
  end

  always @(negedge clk) begin
    logic [4:0] exp, act;
    cycles++;
    exp = {mMode == "run",
           mMode == "run" || mMode == "sleep",
           mMode == "run" || mMode == "sleep" || mMode == "settle" || mMode == "reset",
           mWake, mRst};
    act = {cpuClkEn, periClkEn, oscEn, wakeExcStrobe, resetExcStrobe};
    if (!done) begin
      checks++;
      if (act !== exp) begin
        failures++;
        $display("FAIL %s cycle %0d mode %s: cpu/peri/osc/wake/rst actual=%b expected=%b",
                 curReq, cycles, mMode, act, exp);
      end
    end
    if (cycles > 60000 && !done) begin
      failures++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sleepPulse(input bit sel);
    standbySel = sel; sleepReq = 1'b1; cyc(1); sleepReq = 1'b0; cyc(2);
  endtask

  initial begin
    // R10/R8: both pins low -> hardware standby, oscillator off
    curReq = "R10"; cyc(4);
    curReq = "R9"; hwStbyN = 1'b1; cyc(3);
    resetPinN = 1'b1; cyc(3);

    curReq = "R1"; sleepPulse(1'b0); cyc(2);
    curReq = "R4"; irqReq = 8'h01; cyc(3);
    irqEn = 8'h01; cpuMask = 1'b1; cyc(3);
    periphIrqReq = 1'b1; auxWakeReq = 1'b1; auxWakeEn = 1'b1; cyc(2);
    periphIrqReq = 1'b0; auxWakeReq = 1'b0; irqReq = 8'h00;
    curReq = "R11"; standbySel = 1'b1; sleepReq = 1'b1; cyc(2); sleepReq = 1'b0; standbySel = 1'b0;
    curReq = "R3"; nmiReq = 1'b1; cyc(1); nmiReq = 1'b0; cpuMask = 1'b0; cyc(3);
    sleepPulse(1'b0); irqEn = 8'h80; irqReq = 8'h80; cyc(1); irqReq = 8'h00; cyc(3);
    sleepPulse(1'b0); periphIrqReq = 1'b1; cyc(1); periphIrqReq = 1'b0; cyc(3);
    sleepPulse(1'b0); auxWakeReq = 1'b1; cyc(1); auxWakeReq = 1'b0; cyc(3);
    sleepPulse(1'b0); resetPinN = 1'b0; cyc(2); resetPinN = 1'b1; cyc(3);
    sleepPulse(1'b0); hwStbyN = 1'b0; cyc(2); hwStbyN = 1'b1; cyc(3);

    curReq = "R2"; sleepPulse(1'b1); cyc(2);
    curReq = "R5"; periphIrqReq = 1'b1; cyc(3); periphIrqReq = 1'b0;
    auxWakeEn = 1'b0; auxWakeReq = 1'b1; cyc(3); auxWakeReq = 1'b0;
    irqEn = 8'h00; irqReq = 8'hFF; cyc(3); irqReq = 8'h00;
    curReq = "R7"; cpuMask = 1'b1; irqEn = 8'h04; irqReq = 8'h04; auxWakeEn = 1'b1;
    auxWakeReq = 1'b1; cyc(3);
    irqReq = 8'h00; auxWakeReq = 1'b0; cpuMask = 1'b0;
    curReq = "R6"; settleSel = 3'd0; auxWakeReq = 1'b1; cyc(1); auxWakeReq = 1'b0; cyc(140);
    settleSel = 3'd2; sleepPulse(1'b1); irqEn = 8'h08; irqReq = 8'h08; cyc(1);
    irqReq = 8'h00; settleSel = 3'd5; cyc(530);
    settleSel = 3'd7; sleepPulse(1'b1); nmiReq = 1'b1; cyc(1); nmiReq = 1'b0; cyc(16400);

    curReq = "R10"; settleSel = 3'd0; sleepPulse(1'b1);
    nmiReq = 1'b1; resetPinN = 1'b0; cyc(1); nmiReq = 1'b0; cyc(2); resetPinN = 1'b1; cyc(3);
    sleepPulse(1'b0); nmiReq = 1'b1; resetPinN = 1'b0; hwStbyN = 1'b0; cyc(2);
    nmiReq = 1'b0; hwStbyN = 1'b1; cyc(2); resetPinN = 1'b1; cyc(3);

    curReq = "R9"; sleepPulse(1'b1); nmiReq = 1'b1; cyc(1); nmiReq = 1'b0; cyc(5);
    resetPinN = 1'b0; cyc(2); resetPinN = 1'b1; cyc(3);
    curReq = "R8"; sleepPulse(1'b1); auxWakeReq = 1'b1; cyc(1); auxWakeReq = 1'b0; cyc(4);
    hwStbyN = 1'b0; cyc(3); hwStbyN = 1'b1; cyc(4);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule